// File: doc/BRIEF.md
# Serial EEPROM Single-Byte Random Read Sequencer

This block fetches one byte from a serial EEPROM on a two-wire bus. It does not drive the bus wires itself. It steers a byte-level bus master engine one step at a time. Each step is a command pulse that carries a command code and a data byte. After each pulse the sequencer watches the engine's step-complete flag, its status code and its busy bit before it moves on.

A one-cycle `req_i` latches a 7-bit device address and an offset word. The sequencer then runs a fixed series of steps:

1. Write-addressed selection.
2. The offset byte or bytes.
3. A repeated START.
4. Read-addressed selection.
5. A single data byte, answered with NACK.
6. STOP.

The result comes back on `rdata_o` and `ok_o`, marked by a one-cycle `done_o`. If no device acknowledges its write address within a bounded wait, the bus is released and failure is reported.

The engine accepts a command on the edge where `cmd_vld_o` is high. On that same edge it clears its step-complete flag. For START and STOP it also raises its busy bit. It then raises the flag, or drops busy for STOP, when the step has finished.

Top module: `eeprom_rand_rd`

## Requirements
- R1: After an accepted request, the commands are issued in this order: START, WRITE of `{addr,0}`, the offset byte(s), START, WRITE of `{addr,1}`, READ, STOP. Command codes on `cmd_o` are 0 START, 1 WRITE, 2 READ, 3 STOP.
- R2: When bit 31 of the offset word is 1, two offset bytes are written, bits 15:8 first and then bits 7:0. When bit 31 is 0, only bits 7:0 are written, and bits 30:8 have no effect.
- R3: No command is issued until the previous step has completed with its expected status:
  - 0x08 after the first START and 0x10 after the repeated START.
  - 0x18 after the write address.
  - 0x28 after each offset byte.
  - 0x40 after the read address.
  - 0x58 after the read.
  For both STARTs the busy bit must also be low. STOP completes when busy is low.
- R4: `cmd_ack_en_o` is low when the READ command is issued, so the one data byte is NACKed.
- R5: `rdata_o` takes `eng_rdata_i` on the cycle that status 0x58 is accepted. On a completed read, `ok_o` is 1 at `done_o`.
- R6: If status 0x18 is not accepted within 2^TMO_W-1 waiting cycles after the write address, a STOP is issued, and `done_o` then pulses with `ok_o`=0 and `rdata_o`=0. A status that arrives in time is accepted normally.
- R7: A request that arrives while a sequence is running is ignored. It changes neither the command stream nor the result.
- R8: `done_o` is high for exactly one cycle. `rdata_o` and `ok_o` hold their values until the next accepted request.
- R9: In and after reset, `done_o`, `ok_o`, `rdata_o` and `cmd_vld_o` are 0 and `cmd_ack_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start pulse, accepted only when idle |
| dev_addr_i | input | 7 | Device address |
| offset_i | input | OFF_W | Offset word; the top bit selects a two-byte offset |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte read, or 0 on failure |
| ok_o | output | 1 | 1 when the read completed |
| cmd_vld_o | output | 1 | Command pulse to the engine |
| cmd_o | output | 2 | Command code |
| cmd_data_o | output | 8 | Byte for WRITE commands |
| cmd_ack_en_o | output | 1 | ACK enable level for received bytes |
| eng_irq_i | input | 1 | Engine step-complete flag |
| eng_busy_i | input | 1 | Engine START/STOP request still pending |
| eng_status_i | input | 8 | Engine status code |
| eng_rdata_i | input | 8 | Byte received by the engine |

## Verification
The bench drives the block with a behavioural engine and EEPROM model. In some runs the model raises the step-complete flag early with a wrong status code, or with busy still high. A sequencer that advances on the flag alone would issue a command into a pending step, and the model counts that as a protocol error.

The offset-word runs cover three cases:
- A zero high byte.
- Bit 31 clear with non-zero bits above bit 15.
- A late address acknowledge that still falls inside the timeout window.

A design that chose the offset width wrongly, or dropped the high byte, reads from the wrong location and returns a mismatching byte. Runs with an absent device check that the bus is released with STOP and that failure is reported. A later run checks that the sequencer recovers. A second request injected mid-sequence must leave both the command stream and the result untouched.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

   localparam int DEV_W  = 7;
   localparam int BYTE_W = 8;

   // Engine status codes awaited after each step
   localparam logic [7:0] CODE_START  = 8'h08;
   localparam logic [7:0] CODE_RSTART = 8'h10;
   localparam logic [7:0] CODE_WADDR  = 8'h18;
   localparam logic [7:0] CODE_WBYTE  = 8'h28;
   localparam logic [7:0] CODE_RADDR  = 8'h40;
   localparam logic [7:0] CODE_RNACK  = 8'h58;

   typedef enum logic [1:0] {
      CMD_START = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_READ  = 2'd2,
      CMD_STOP  = 2'd3
   } eng_cmd_e;

   typedef enum logic [2:0] {
      ST_START,
      ST_WADDR,
      ST_OFFH,
      ST_OFFL,
      ST_RSTART,
      ST_RADDR,
      ST_READ,
      ST_STOP
   } step_e;

   typedef enum logic [1:0] {
      WAIT_CODE,       // flag and matching status
      WAIT_CODE_IDLE,  // flag, matching status and busy low
      WAIT_IDLE        // busy low only
   } wait_e;

   typedef struct packed {
      eng_cmd_e         cmd;
      logic [BYTE_W-1:0] data;
      logic [7:0]       code;
      wait_e            kind;
   } step_ctl_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_WAIT
   } seq_state_e;

endpackage

// File: rtl/eerd_step_decode.sv
module eerd_step_decode
   import eerd_pkg::*;
(
   input  step_e             step,
   input  logic [DEV_W-1:0]  dev_addr,
   input  logic [BYTE_W-1:0] off_hi,
   input  logic [BYTE_W-1:0] off_lo,
   input  logic              two_byte,
   output step_ctl_t         ctl,
   output step_e             nxt
);

   always_comb begin
      ctl = '{cmd: CMD_START, data: '0, code: CODE_START, kind: WAIT_CODE_IDLE};
      nxt = step;
      case (step)
         ST_START: begin
            nxt = ST_WADDR;
         end
         ST_WADDR: begin
            ctl = '{cmd: CMD_WRITE, data: {dev_addr, 1'b0}, code: CODE_WADDR, kind: WAIT_CODE};
            nxt = two_byte ? ST_OFFH : ST_OFFL;
         end
         ST_OFFH: begin
            ctl = '{cmd: CMD_WRITE, data: off_hi, code: CODE_WBYTE, kind: WAIT_CODE};
            nxt = ST_OFFL;
         end
         ST_OFFL: begin
            ctl = '{cmd: CMD_WRITE, data: off_lo, code: CODE_WBYTE, kind: WAIT_CODE};
            nxt = ST_RSTART;
         end
         ST_RSTART: begin
            ctl = '{cmd: CMD_START, data: '0, code: CODE_RSTART, kind: WAIT_CODE_IDLE};
            nxt = ST_RADDR;
         end
         ST_RADDR: begin
            ctl = '{cmd: CMD_WRITE, data: {dev_addr, 1'b1}, code: CODE_RADDR, kind: WAIT_CODE};
            nxt = ST_READ;
         end
         ST_READ: begin
            ctl = '{cmd: CMD_READ, data: '0, code: CODE_RNACK, kind: WAIT_CODE};
            nxt = ST_STOP;
         end
         ST_STOP: begin
            ctl = '{cmd: CMD_STOP, data: '0, code: 8'h00, kind: WAIT_IDLE};
            nxt = ST_STOP;
         end
         default: begin
            nxt = ST_STOP;
         end
      endcase
   end

endmodule

// File: rtl/eerd_watchdog.sv
module eerd_watchdog #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("eerd_watchdog: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign expired = &cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run && !expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: once the window has expired it stays expired until cleared
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !clear) |=> expired);

endmodule

// File: rtl/eeprom_rand_rd.sv
module eeprom_rand_rd
   import eerd_pkg::*;
#(
   parameter int TMO_W = 8,
   parameter int OFF_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [6:0]       dev_addr_i,
   input  logic [OFF_W-1:0] offset_i,
   output logic             done_o,
   output logic [7:0]       rdata_o,
   output logic             ok_o,
   output logic             cmd_vld_o,
   output logic [1:0]       cmd_o,
   output logic [7:0]       cmd_data_o,
   output logic             cmd_ack_en_o,
   input  logic             eng_irq_i,
   input  logic             eng_busy_i,
   input  logic [7:0]       eng_status_i,
   input  logic [7:0]       eng_rdata_i
);

   localparam int SEL_BIT = OFF_W - 1;

   generate
      if (OFF_W < 17) begin : g_bad_off
         $error("eeprom_rand_rd: OFF_W must leave room for a 16-bit offset and a select bit");
      end
   endgenerate

   seq_state_e        state_q;
   step_e             step_q;
   step_e             step_nxt;
   step_ctl_t         ctl;
   logic [DEV_W-1:0]  addr_q;
   logic [BYTE_W-1:0] hi_q;
   logic [BYTE_W-1:0] lo_q;
   logic              two_q;
   logic              got_q;
   logic              ack_en_q;
   logic              step_ok;
   logic              wd_expired;
   logic              timeout;
   logic              unused_off_bits;

   assign unused_off_bits = ^offset_i[SEL_BIT-1:16];

   eerd_step_decode u_dec (
      .step     (step_q),
      .dev_addr (addr_q),
      .off_hi   (hi_q),
      .off_lo   (lo_q),
      .two_byte (two_q),
      .ctl      (ctl),
      .nxt      (step_nxt)
   );

   eerd_watchdog #(.CNT_W(TMO_W)) u_wd (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q == SQ_ISSUE),
      .run     (state_q == SQ_WAIT && step_q == ST_WADDR),
      .expired (wd_expired)
   );

   always_comb begin
      case (ctl.kind)
         WAIT_CODE:      step_ok = eng_irq_i && (eng_status_i == ctl.code);
         WAIT_CODE_IDLE: step_ok = eng_irq_i && (eng_status_i == ctl.code) && !eng_busy_i;
         default:        step_ok = !eng_busy_i;
      endcase
   end

   assign timeout = (state_q == SQ_WAIT) && (step_q == ST_WADDR) && !step_ok && wd_expired;

   assign cmd_vld_o    = (state_q == SQ_ISSUE);
   assign cmd_o        = ctl.cmd;
   assign cmd_data_o   = ctl.data;
   assign cmd_ack_en_o = ack_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         step_q   <= ST_START;
         addr_q   <= '0;
         hi_q     <= '0;
         lo_q     <= '0;
         two_q    <= 1'b0;
         got_q    <= 1'b0;
         ack_en_q <= 1'b1;
         done_o   <= 1'b0;
         ok_o     <= 1'b0;
         rdata_o  <= '0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (req_i) begin
                  addr_q   <= dev_addr_i;
                  hi_q     <= offset_i[15:8];
                  lo_q     <= offset_i[7:0];
                  two_q    <= offset_i[SEL_BIT];
                  step_q   <= ST_START;
                  got_q    <= 1'b0;
                  ack_en_q <= 1'b1;
                  ok_o     <= 1'b0;
                  rdata_o  <= '0;
                  state_q  <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               state_q <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (step_ok) begin
                  if (step_q == ST_STOP) begin
                     done_o  <= 1'b1;
                     ok_o    <= got_q;
                     state_q <= SQ_IDLE;
                  end else begin
                     if (step_q == ST_READ) begin
                        rdata_o <= eng_rdata_i;
                        got_q   <= 1'b1;
                     end
                     if (step_nxt == ST_READ) begin
                        ack_en_q <= 1'b0;
                     end
                     step_q  <= step_nxt;
                     state_q <= SQ_ISSUE;
                  end
               end else if (timeout) begin
                  step_q  <= ST_STOP;
                  state_q <= SQ_ISSUE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R8: completion is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4: the read command always goes out with ACK disabled
   p_read_nack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_o && cmd_o == CMD_READ) |-> !cmd_ack_en_o);

   // R3: one command per step, never back to back
   p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld_o |=> !cmd_vld_o);

   // R6: a failed sequence reports a zero byte
   p_fail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ok_o) |-> (rdata_o == 8'h00));

   // R1: completion always follows the STOP step
   p_stop_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(step_q) == ST_STOP);

   // R7: latched request fields stay frozen while a sequence runs
   p_req_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SQ_IDLE) |=> ($stable(addr_q) && $stable(hi_q) && $stable(lo_q) && $stable(two_q)));

endmodule

// File: tb/eeprom_rand_rd_test.sv
module eeprom_rand_rd_test;

   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 150000;

   typedef struct packed {
      logic [6:0]  a;
      logic [31:0] off;
      logic        pres;
      logic [7:0]  dly;
      logic        gl;
      logic        poke;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{7'h50, 32'h0000_0012, 1'b1, 8'd3,   1'b0, 1'b0},
      '{7'h50, 32'h8000_1234, 1'b1, 8'd3,   1'b1, 1'b0},
      '{7'h57, 32'h8000_00FF, 1'b1, 8'd3,   1'b0, 1'b0},
      '{7'h50, 32'h7FFF_ABCD, 1'b1, 8'd3,   1'b1, 1'b1},
      '{7'h51, 32'h0000_0044, 1'b0, 8'd3,   1'b0, 1'b0},
      '{7'h53, 32'h8000_BEEF, 1'b1, 8'd200, 1'b0, 1'b0},
      '{7'h2A, 32'h0000_0000, 1'b0, 8'd3,   1'b1, 1'b0},
      '{7'h50, 32'h8000_0001, 1'b1, 8'd3,   1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [6:0]  addr = '0;
   logic [31:0] off = '0;
   logic        done_o, ok_o, cmd_vld_o, cmd_ack_en_o;
   logic [7:0]  rdata_o, cmd_data_o;
   logic [1:0]  cmd_o;
   logic        irq = 1'b0, busy = 1'b0;
   logic [7:0]  status = 8'hF8, erdata = 8'h00;

   int checks = 0;
   int fails  = 0;

   eeprom_rand_rd uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .dev_addr_i(addr), .offset_i(off),
      .done_o(done_o), .rdata_o(rdata_o), .ok_o(ok_o),
      .cmd_vld_o(cmd_vld_o), .cmd_o(cmd_o), .cmd_data_o(cmd_data_o), .cmd_ack_en_o(cmd_ack_en_o),
      .eng_irq_i(irq), .eng_busy_i(busy), .eng_status_i(status), .eng_rdata_i(erdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- engine + EEPROM model ----------------
   logic [6:0]  m_dev = '0;
   logic [7:0]  m_dly = 8'd3;
   bit          m_gl = 1'b0;
   int          m_proto = 0, m_nofs = 0, m_stops = 0, m_nlog = 0;
   logic [9:0]  m_log [0:15];
   bit          m_pend = 1'b0, m_own = 1'b0, m_aphase = 1'b0, m_rdack = 1'b1;
   int          m_cnt = 0;
   logic [1:0]  m_cmd = 2'd0;
   logic [7:0]  m_data = 8'h00;
   logic [15:0] m_ptr = 16'h0000;

   function automatic logic [7:0] memf(input logic [15:0] p);
      return p[7:0] ^ {p[14:8], p[15]} ^ 8'hA5;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0; busy <= 1'b0; status <= 8'hF8;
         m_pend = 1'b0; m_own = 1'b0; m_aphase = 1'b0;
      end else if (cmd_vld_o) begin
         if (m_pend) m_proto++;
         if (m_nlog < 16) m_log[m_nlog] = {cmd_o, cmd_data_o};
         m_nlog++;
         m_pend = 1'b1; m_cmd = cmd_o; m_data = cmd_data_o;
         if (cmd_o == 2'd2) m_rdack = cmd_ack_en_o;
         m_cnt = (cmd_o == 2'd1 && m_aphase && !cmd_data_o[0]) ? int'(m_dly) : 3;
         irq <= 1'b0;
         busy <= (cmd_o == 2'd0 || cmd_o == 2'd3);
      end else if (m_pend) begin
         m_cnt--;
         if (m_cnt == 0) begin
            m_pend = 1'b0;
            case (m_cmd)
               2'd0: begin
                  status <= m_own ? 8'h10 : 8'h08;
                  m_own = 1'b1; m_aphase = 1'b1;
                  irq <= 1'b1; busy <= 1'b0;
               end
               2'd1: begin
                  if (m_aphase) begin
                     m_aphase = 1'b0;
                     if (m_data[0] == 1'b0) begin
                        status <= (m_data[7:1] == m_dev) ? 8'h18 : 8'h20;
                        m_ptr = 16'h0000;
                     end else begin
                        status <= (m_data[7:1] == m_dev) ? 8'h40 : 8'h48;
                     end
                  end else begin
                     status <= 8'h28;
                     m_ptr = {m_ptr[7:0], m_data};
                     m_nofs++;
                  end
                  irq <= 1'b1;
               end
               2'd2: begin
                  status <= m_rdack ? 8'h50 : 8'h58;
                  erdata <= memf(m_ptr);
                  irq <= 1'b1;
               end
               default: begin
                  status <= 8'hF8; busy <= 1'b0; m_own = 1'b0; m_stops++;
               end
            endcase
         end else if (m_gl && m_cnt == 1 && m_cmd != 2'd3) begin
            irq <= 1'b1;
            if (m_cmd == 2'd0) status <= m_own ? 8'h10 : 8'h08;
            else status <= 8'h30;
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit cond, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic [9:0] exp_log [0:15];
      int         n = 0;
      int         waited = 0;
      bit         two = v.off[31];
      logic [7:0] exp_d;
      bit         seq_ok = 1'b1;

      m_dev = v.pres ? v.a : (v.a ^ 7'h01);
      m_dly = v.dly; m_gl = v.gl;
      m_nlog = 0; m_proto = 0; m_nofs = 0; m_stops = 0; m_rdack = 1'b1;
      exp_d = v.pres ? memf(two ? v.off[15:0] : {8'h00, v.off[7:0]}) : 8'h00;

      exp_log[n++] = {2'd0, 8'h00};
      exp_log[n++] = {2'd1, v.a, 1'b0};
      if (v.pres) begin
         if (two) exp_log[n++] = {2'd1, v.off[15:8]};
         exp_log[n++] = {2'd1, v.off[7:0]};
         exp_log[n++] = {2'd0, 8'h00};
         exp_log[n++] = {2'd1, v.a, 1'b1};
         exp_log[n++] = {2'd2, 8'h00};
      end
      exp_log[n++] = {2'd3, 8'h00};

      @(negedge clk);
      req = 1'b1; addr = v.a; off = v.off;
      @(negedge clk);
      req = 1'b0;
      while (!done_o && waited < 3000) begin
         if (v.poke && (waited == 4 || waited == 20)) begin
            req = 1'b1; addr = 7'h11; off = 32'h8000_5555;   // R7 stray request
         end else begin
            req = 1'b0;
         end
         @(negedge clk);
         waited++;
      end
      req = 1'b0;
      chk(done_o, "R8", "done seen", done_o, 1);
      chk(ok_o == v.pres, v.pres ? "R5" : "R6", "ok flag", ok_o, v.pres);
      chk(rdata_o == exp_d, v.pres ? "R5" : "R6", "read byte", rdata_o, exp_d);
      @(negedge clk);
      chk(!done_o, "R8", "done single cycle", done_o, 0);
      repeat (6) @(negedge clk);
      chk(ok_o == v.pres && rdata_o == exp_d, "R8", "outputs hold", {ok_o, rdata_o}, {v.pres, exp_d});

      if (m_nlog != n) seq_ok = 1'b0;
      for (int i = 0; i < n && i < 16; i++) if (m_log[i] != exp_log[i]) seq_ok = 1'b0;
      chk(seq_ok, v.poke ? "R7" : "R1", "command stream", m_nlog, n);
      chk(m_proto == 0, "R3", "no command into a pending step", m_proto, 0);
      if (v.pres) begin
         chk(m_nofs == (two ? 2 : 1), "R2", "offset byte count", m_nofs, two ? 2 : 1);
         chk(m_rdack == 1'b0, "R4", "ack enable at read", m_rdack, 0);
      end else begin
         chk(m_stops == 1, "R6", "STOP after timeout", m_stops, 1);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (LIMIT) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", LIMIT, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk(!done_o && !ok_o && rdata_o == 8'h00 && !cmd_vld_o && cmd_ack_en_o, "R9",
          "state during reset", {done_o, ok_o, rdata_o, cmd_vld_o, cmd_ack_en_o}, 12'h001);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!done_o && !ok_o && rdata_o == 8'h00 && !cmd_vld_o && cmd_ack_en_o, "R9",
          "state after reset", {done_o, ok_o, rdata_o, cmd_vld_o, cmd_ack_en_o}, 12'h001);

      for (int k = 0; k < NV; k++) begin
         run_vec(VECS[k]);
      end

      // back-to-back repeat of a two-byte read after the vector walk (R2, R5)
      run_vec('{7'h55, 32'hFFFF_0F0F, 1'b1, 8'd5, 1'b1, 1'b1});

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule